// File: doc/BRIEF.md
# Speculative L1 Line-State Tracker

This block holds per-line speculation state for the private data L1 of one core. The core runs threads speculatively, and every thread carries a 2-bit speculation rank. A smaller rank means an earlier, less speculative thread. The tag array is direct-mapped.

The tracker sees two kinds of event:
- the core's own loads and stores, which allocate the line and mark it as speculatively read or modified;
- writes snooped from the shared write bus, each tagged with the writer's rank.

A snooped write from an earlier thread invalidates the matching line. If the local thread has already read that line, the read came too early. The tracker then raises a one-cycle restart pulse and discards all speculatively written lines at once. A snooped write from a later thread must stay invisible to this thread, so it only marks the line as pre-invalidated. Those marks are applied in bulk when the thread commits. The sequencer drives commit and squash, and the tracker reports each cycle which lines it invalidated.

An address is `{tag, index}`: the low `IDX_W` bits select the line and the upper `TAG_W` bits are compared with the stored tag. All outputs are registered and change one clock edge after the event that causes them.

Top module: `spec_tag_tracker`

## Requirements
- R1: After reset, every line is invalid, no read, modified or pre-invalidate bit is set, and `viol_o` and `inv_mask_o` are zero.
- R2: A local access allocates its line. If the line is invalid or holds another tag, the tag is written and all three bits are cleared. Then a load (`acc_store_i`=0) sets the read bit and a store (`acc_store_i`=1) sets the modified bit. Read, modified and pre-invalidate bits are only ever set on valid lines.
- R3: A snooped write from an earlier rank that hits a line whose read bit is clear does three things: it invalidates that line, sets its bit in `inv_mask_o` for one cycle, and raises no violation.
- R4: A snooped write from an earlier rank that hits a line whose read bit is set causes the following on the next cycle:
  - `viol_o` pulses for exactly one cycle;
  - the snooped line and every valid modified line are invalidated;
  - `inv_mask_o` marks exactly those lines;
  - all read and modified bits are cleared.
- R5: A snooped write from a later rank that hits a line sets that line's pre-invalidate bit. The line stays valid and no violation is raised.
- R6: A snooped write that carries the core's own rank, or that misses in the tag array, changes no state and raises no violation.
- R7: On commit, every valid line with its pre-invalidate bit set is invalidated and shown in `inv_mask_o`. All read, modified and pre-invalidate bits are then clear.
- R8: On squash, every valid modified line is invalidated and shown in `inv_mask_o`, and all read and modified bits are cleared. Pre-invalidate bits on lines that stay valid are kept.
- R9: Squash overrides commit, and both override snoop and local access in the same cycle. In a cycle where a violation is detected, the local access is dropped. Otherwise the snoop is applied first and the local access after it.
- R10: Ranks are compared as unsigned numbers: a snoop rank below `my_rank_i` is earlier and one above it is later.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| my_rank_i | input | 2 | Rank of the thread running on this core |
| acc_valid_i | input | 1 | Local access this cycle |
| acc_store_i | input | 1 | 1 = store, 0 = load |
| acc_addr_i | input | IDX_W+TAG_W | Local access address {tag, index} |
| snp_valid_i | input | 1 | Snooped write this cycle |
| snp_rank_i | input | 2 | Rank of the snooped writer |
| snp_addr_i | input | IDX_W+TAG_W | Snooped write address {tag, index} |
| thr_commit_i | input | 1 | Current thread completes |
| thr_squash_i | input | 1 | Current thread is squashed |
| viol_o | output | 1 | One-cycle restart pulse |
| inv_mask_o | output | 2**IDX_W | Lines invalidated by the last update |
| line_valid_o | output | 2**IDX_W | Per-line valid |
| line_rd_o | output | 2**IDX_W | Per-line speculatively-read bit |
| line_mod_o | output | 2**IDX_W | Per-line speculatively-modified bit |
| line_pinv_o | output | 2**IDX_W | Per-line pre-invalidate bit |

## Verification
A wrong bit in the line state shows on the per-line vectors one edge after the event that set it. It also shows later as an unexpected `inv_mask_o` pattern at the next commit or squash. A missed rank comparison appears as a missing or extra `viol_o` pulse on the cycle after the snoop. A line that wrongly survives invalidation becomes visible at the following bulk clear. The bench therefore compares every output vector on every cycle, so a corrupted bit is caught one edge after it appears.

// File: rtl/spec_tag_pkg.sv
package spec_tag_pkg;
    // Relation of a snooped writer to the local thread
    typedef enum logic [1:0] {
        SNP_SELF    = 2'd0,
        SNP_EARLIER = 2'd1,
        SNP_LATER   = 2'd2
    } snp_class_e;
endpackage

// File: rtl/spec_rank_cmp.sv
module spec_rank_cmp #(
    parameter int RANK_W = 2
) (
    input  logic [RANK_W-1:0]       mine_i,
    input  logic [RANK_W-1:0]       theirs_i,
    output spec_tag_pkg::snp_class_e cls_o
);
    import spec_tag_pkg::*;
    // Smaller rank is less speculative (R10)
    always_comb begin
        if (theirs_i < mine_i)      cls_o = SNP_EARLIER;
        else if (theirs_i > mine_i) cls_o = SNP_LATER;
        else                        cls_o = SNP_SELF;
    end
endmodule

// File: rtl/spec_line_lookup.sv
module spec_line_lookup #(
    parameter int IDX_W = 3,
    parameter int TAG_W = 4,
    localparam int LINES  = 1 << IDX_W,
    localparam int ADDR_W = IDX_W + TAG_W
) (
    input  logic [ADDR_W-1:0]      addr_i,
    input  logic [LINES-1:0]       valid_i,
    input  logic [LINES*TAG_W-1:0] tags_i,
    output logic [IDX_W-1:0]       idx_o,
    output logic [TAG_W-1:0]       tag_o,
    output logic                   hit_o
);
    assign idx_o = addr_i[IDX_W-1:0];
    assign tag_o = addr_i[ADDR_W-1:IDX_W];
    assign hit_o = valid_i[idx_o] && (tags_i[idx_o*TAG_W +: TAG_W] == tag_o);
endmodule

// File: rtl/spec_tag_tracker.sv
module spec_tag_tracker #(
    parameter int IDX_W  = 3,
    parameter int TAG_W  = 4,
    parameter int RANK_W = 2,
    localparam int LINES  = 1 << IDX_W,
    localparam int ADDR_W = IDX_W + TAG_W
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [RANK_W-1:0] my_rank_i,
    input  logic              acc_valid_i,
    input  logic              acc_store_i,
    input  logic [ADDR_W-1:0] acc_addr_i,
    input  logic              snp_valid_i,
    input  logic [RANK_W-1:0] snp_rank_i,
    input  logic [ADDR_W-1:0] snp_addr_i,
    input  logic              thr_commit_i,
    input  logic              thr_squash_i,
    output logic              viol_o,
    output logic [LINES-1:0]  inv_mask_o,
    output logic [LINES-1:0]  line_valid_o,
    output logic [LINES-1:0]  line_rd_o,
    output logic [LINES-1:0]  line_mod_o,
    output logic [LINES-1:0]  line_pinv_o
);
    import spec_tag_pkg::*;

    typedef struct packed {
        logic             valid;
        logic [TAG_W-1:0] tag;
        logic             rd;
        logic             md;
        logic             pinv;
    } line_t;

    typedef struct packed {
        line_t [LINES-1:0] lines;
        logic              viol;
        logic [LINES-1:0]  inv;
    } state_t;

    state_t st_d, st_q;

    // Flattened views of the array for lookups and outputs
    logic [LINES-1:0]       valid_vec;
    logic [LINES*TAG_W-1:0] tag_flat;

    generate
        for (genvar g = 0; g < LINES; g++) begin : g_flat
            assign valid_vec[g]                  = st_q.lines[g].valid;
            assign tag_flat[g*TAG_W +: TAG_W]    = st_q.lines[g].tag;
            assign line_valid_o[g]               = st_q.lines[g].valid;
            assign line_rd_o[g]                  = st_q.lines[g].rd;
            assign line_mod_o[g]                 = st_q.lines[g].md;
            assign line_pinv_o[g]                = st_q.lines[g].pinv;
        end
    endgenerate

    assign viol_o     = st_q.viol;
    assign inv_mask_o = st_q.inv;

    logic [IDX_W-1:0] acc_idx, snp_idx;
    logic [TAG_W-1:0] acc_tag, snp_tag;
    logic             acc_hit, snp_hit;
    snp_class_e       snp_cls;

    spec_line_lookup #(.IDX_W(IDX_W), .TAG_W(TAG_W)) u_acc_lu (
        .addr_i (acc_addr_i), .valid_i(valid_vec), .tags_i(tag_flat),
        .idx_o  (acc_idx),    .tag_o  (acc_tag),   .hit_o (acc_hit)
    );

    spec_line_lookup #(.IDX_W(IDX_W), .TAG_W(TAG_W)) u_snp_lu (
        .addr_i (snp_addr_i), .valid_i(valid_vec), .tags_i(tag_flat),
        .idx_o  (snp_idx),    .tag_o  (snp_tag),   .hit_o (snp_hit)
    );

    spec_rank_cmp #(.RANK_W(RANK_W)) u_rank (
        .mine_i (my_rank_i), .theirs_i(snp_rank_i), .cls_o(snp_cls)
    );

    logic snp_kill;
    logic acc_alloc;

    always_comb begin
        st_d      = st_q;
        st_d.viol = 1'b0;
        st_d.inv  = '0;
        snp_kill  = snp_valid_i && snp_hit && (snp_cls == SNP_EARLIER);
        acc_alloc = !acc_hit || (snp_kill && (snp_idx == acc_idx));

        if (thr_squash_i) begin
            // Discard speculative writes; keep pending pre-invalidates (R8)
            for (int i = 0; i < LINES; i++) begin
                if (st_d.lines[i].valid && st_d.lines[i].md) begin
                    st_d.inv[i]   = 1'b1;
                    st_d.lines[i] = '0;
                end
                st_d.lines[i].rd = 1'b0;
                st_d.lines[i].md = 1'b0;
            end
        end else if (thr_commit_i) begin
            // Apply deferred invalidations from later threads (R7)
            for (int i = 0; i < LINES; i++) begin
                if (st_d.lines[i].valid && st_d.lines[i].pinv) begin
                    st_d.inv[i]   = 1'b1;
                    st_d.lines[i] = '0;
                end
                st_d.lines[i].rd   = 1'b0;
                st_d.lines[i].md   = 1'b0;
                st_d.lines[i].pinv = 1'b0;
            end
        end else begin
            if (snp_valid_i && snp_hit) begin
                if (snp_cls == SNP_EARLIER) begin
                    st_d.inv[snp_idx]   = 1'b1;
                    st_d.viol           = st_q.lines[snp_idx].rd;
                    st_d.lines[snp_idx] = '0;
                end else if (snp_cls == SNP_LATER) begin
                    st_d.lines[snp_idx].pinv = 1'b1;
                end
            end
            if (st_d.viol) begin
                // Too-early read detected: drop all speculative data (R4)
                for (int i = 0; i < LINES; i++) begin
                    if (st_d.lines[i].valid && st_d.lines[i].md) begin
                        st_d.inv[i]   = 1'b1;
                        st_d.lines[i] = '0;
                    end
                    st_d.lines[i].rd = 1'b0;
                    st_d.lines[i].md = 1'b0;
                end
            end else if (acc_valid_i) begin
                if (acc_alloc) begin
                    st_d.lines[acc_idx]       = '0;
                    st_d.lines[acc_idx].valid = 1'b1;
                    st_d.lines[acc_idx].tag   = acc_tag;
                end
                if (acc_store_i) st_d.lines[acc_idx].md = 1'b1;
                else             st_d.lines[acc_idx].rd = 1'b1;
            end
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end
endmodule

// File: rtl/spec_tag_tracker_chk.sv
module spec_tag_tracker_chk #(
    parameter int IDX_W  = 3,
    parameter int TAG_W  = 4,
    parameter int RANK_W = 2,
    localparam int LINES  = 1 << IDX_W,
    localparam int ADDR_W = IDX_W + TAG_W
) (
    input logic              clk,
    input logic              rst_n,
    input logic [RANK_W-1:0] my_rank_i,
    input logic              acc_valid_i,
    input logic              snp_valid_i,
    input logic [RANK_W-1:0] snp_rank_i,
    input logic [ADDR_W-1:0] snp_addr_i,
    input logic              thr_commit_i,
    input logic              thr_squash_i,
    input logic              viol_o,
    input logic [LINES-1:0]  inv_mask_o,
    input logic [LINES-1:0]  line_valid_o,
    input logic [LINES-1:0]  line_rd_o,
    input logic [LINES-1:0]  line_mod_o,
    input logic [LINES-1:0]  line_pinv_o
);
    // R2: state bits only on valid lines
    a_r2_bits_on_valid: assert property (@(posedge clk) disable iff (!rst_n)
        ((line_rd_o | line_mod_o | line_pinv_o) & ~line_valid_o) == '0);

    // R4: a restart pulse leaves no speculative read or write marks
    a_r4_viol_clears: assert property (@(posedge clk) disable iff (!rst_n)
        viol_o |-> (line_rd_o == '0 && line_mod_o == '0));

    // R4, R10: a restart pulse only follows an earlier-rank snoop
    a_r4_viol_cause: assert property (@(posedge clk) disable iff (!rst_n)
        viol_o |-> ($past(snp_valid_i) && ($past(snp_rank_i) < $past(my_rank_i))
                    && !$past(thr_commit_i) && !$past(thr_squash_i)));

    // R4: the pulse lasts one cycle (no snoop can re-trigger on a clean state)
    a_r4_single_pulse: assert property (@(posedge clk) disable iff (!rst_n)
        viol_o |=> !viol_o);

    // R7: commit leaves every mark clear
    a_r7_commit_clears: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(thr_commit_i) && !$past(thr_squash_i)) |->
        (line_pinv_o == '0 && line_rd_o == '0 && line_mod_o == '0 && !viol_o));

    // R8: squash removes read/modified marks and never signals a restart
    a_r8_squash_clears: assert property (@(posedge clk) disable iff (!rst_n)
        $past(thr_squash_i) |-> (line_rd_o == '0 && line_mod_o == '0 && !viol_o));

    // R6: own-rank snoop with no other event leaves the state untouched
    a_r6_self_ignored: assert property (@(posedge clk) disable iff (!rst_n)
        $past(snp_valid_i && (snp_rank_i == my_rank_i) && !acc_valid_i
              && !thr_commit_i && !thr_squash_i) |->
        ($stable(line_valid_o) && $stable(line_rd_o) && $stable(line_mod_o)
         && $stable(line_pinv_o) && inv_mask_o == '0 && !viol_o));

    // R5: a later-rank snoop never invalidates
    a_r5_later_keeps: assert property (@(posedge clk) disable iff (!rst_n)
        $past(snp_valid_i && (snp_rank_i > my_rank_i) && !acc_valid_i
              && !thr_commit_i && !thr_squash_i) |->
        ($stable(line_valid_o) && inv_mask_o == '0 && !viol_o));

    // R3, R4: snoop address must be known whenever a snoop is presented
    a_r3_snp_addr_known: assert property (@(posedge clk) disable iff (!rst_n)
        snp_valid_i |-> !$isunknown(snp_addr_i));
endmodule

bind spec_tag_tracker spec_tag_tracker_chk #(
    .IDX_W(IDX_W), .TAG_W(TAG_W), .RANK_W(RANK_W)
) u_chk (
    .clk(clk), .rst_n(rst_n), .my_rank_i(my_rank_i), .acc_valid_i(acc_valid_i),
    .snp_valid_i(snp_valid_i), .snp_rank_i(snp_rank_i), .snp_addr_i(snp_addr_i),
    .thr_commit_i(thr_commit_i), .thr_squash_i(thr_squash_i), .viol_o(viol_o),
    .inv_mask_o(inv_mask_o), .line_valid_o(line_valid_o), .line_rd_o(line_rd_o),
    .line_mod_o(line_mod_o), .line_pinv_o(line_pinv_o)
);

// File: tb/sim_spec_tag_tracker.sv
`timescale 1ns/1ps
module sim_spec_tag_tracker;
    localparam int IDX_W = 3;
    localparam int TAG_W = 4;
    localparam int LINES = 1 << IDX_W;
    localparam int AW    = IDX_W + TAG_W;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic [1:0]    my_rank = 2'd2;
    logic          acc_v = 1'b0, acc_st = 1'b0;
    logic [AW-1:0] acc_a = '0;
    logic          snp_v = 1'b0;
    logic [1:0]    snp_r = '0;
    logic [AW-1:0] snp_a = '0;
    logic          cmt = 1'b0, sqh = 1'b0;
    logic              viol;
    logic [LINES-1:0]  inv, lv, lr, lm, lp;

    always #5 clk = ~clk;

    spec_tag_tracker #(.IDX_W(IDX_W), .TAG_W(TAG_W), .RANK_W(2)) u0 (
        .clk(clk), .rst_n(rst_n), .my_rank_i(my_rank), .acc_valid_i(acc_v),
        .acc_store_i(acc_st), .acc_addr_i(acc_a), .snp_valid_i(snp_v),
        .snp_rank_i(snp_r), .snp_addr_i(snp_a), .thr_commit_i(cmt),
        .thr_squash_i(sqh), .viol_o(viol), .inv_mask_o(inv), .line_valid_o(lv),
        .line_rd_o(lr), .line_mod_o(lm), .line_pinv_o(lp)
    );

    int checks = 0, failures = 0;
    bit done = 0;

    // Reference model state
    bit             mv[LINES], mr[LINES], mm[LINES], mp[LINES];
    bit [TAG_W-1:0] mt[LINES];
    bit             e_viol;
    bit [LINES-1:0] e_inv;

    function automatic [AW-1:0] mk(input int tag, input int idx);
        return AW'((tag << IDX_W) | idx);
    endfunction

    function automatic void clr_line(input int i);
        mv[i] = 0; mr[i] = 0; mm[i] = 0; mp[i] = 0; mt[i] = '0;
    endfunction

    function automatic void drop_mod();
        for (int i = 0; i < LINES; i++) begin
            if (mv[i] && mm[i]) begin e_inv[i] = 1; clr_line(i); end
            mr[i] = 0; mm[i] = 0;
        end
    endfunction

    // Next-state from the requirements (R2..R10)
    function automatic void model_step();
        int si, ai;
        bit shit, ahit;
        e_viol = 0; e_inv = '0;
        if (sqh) begin
            drop_mod();
        end else if (cmt) begin
            for (int i = 0; i < LINES; i++) begin
                if (mv[i] && mp[i]) begin e_inv[i] = 1; clr_line(i); end
                mr[i] = 0; mm[i] = 0; mp[i] = 0;
            end
        end else begin
            si = int'(snp_a[IDX_W-1:0]);
            shit = mv[si] && (mt[si] == snp_a[AW-1:IDX_W]);
            if (snp_v && shit && snp_r < my_rank) begin
                e_inv[si] = 1; e_viol = mr[si]; clr_line(si);
            end else if (snp_v && shit && snp_r > my_rank) begin
                mp[si] = 1;
            end
            if (e_viol) drop_mod();
            else if (acc_v) begin
                ai = int'(acc_a[IDX_W-1:0]);
                ahit = mv[ai] && (mt[ai] == acc_a[AW-1:IDX_W]);
                if (!ahit) begin clr_line(ai); mv[ai] = 1; mt[ai] = acc_a[AW-1:IDX_W]; end
                if (acc_st) mm[ai] = 1; else mr[ai] = 1;
            end
        end
    endfunction

    task automatic compare(input string tag);
        bit [LINES-1:0] ev, er, em, ep;
        for (int i = 0; i < LINES; i++) begin
            ev[i] = mv[i]; er[i] = mr[i]; em[i] = mm[i]; ep[i] = mp[i];
        end
        checks++;
        if (viol !== e_viol || inv !== e_inv || lv !== ev || lr !== er ||
            lm !== em || lp !== ep) begin
            failures++;
            $display("FAIL %s: viol=%0b inv=%b v=%b r=%b m=%b p=%b expected viol=%0b inv=%b v=%b r=%b m=%b p=%b",
                     tag, viol, inv, lv, lr, lm, lp, e_viol, e_inv, ev, er, em, ep);
        end
    endtask

    task automatic idle();
        acc_v = 0; acc_st = 0; snp_v = 0; cmt = 0; sqh = 0;
    endtask

    // Inputs already set at a negedge; clock once and check at the next negedge
    task automatic step(input string tag);
        model_step();
        @(posedge clk);
        @(negedge clk);
        compare(tag);
        idle();
    endtask

    task automatic acc(input bit st, input [AW-1:0] a);
        acc_v = 1; acc_st = st; acc_a = a;
    endtask

    task automatic snp(input [1:0] r, input [AW-1:0] a);
        snp_v = 1; snp_r = r; snp_a = a;
    endtask

    initial begin
        #(200000 * 10);
        checks++; failures++;
        $display("FAIL watchdog: actual=timeout expected=finish");
        if (!done) begin
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end

    initial begin
        string tg;
        void'($urandom(32'd1234));
        for (int i = 0; i < LINES; i++) clr_line(i);
        e_viol = 0; e_inv = '0;
        repeat (3) @(negedge clk);
        rst_n = 1;
        @(negedge clk);
        compare("R1 reset");

        // Directed cases, local rank 2
        acc(0, mk(3, 1));            step("R2 load sets read");
        acc(1, mk(3, 2));            step("R2 store sets mod");
        acc(1, mk(5, 2));            step("R2 replace tag");
        snp(2'd3, mk(3, 1));         step("R5 later snoop pinv");
        snp(2'd2, mk(3, 1));         step("R6 own rank ignored");
        snp(2'd0, mk(7, 1));         step("R6 snoop miss ignored");
        acc(1, mk(2, 6));            step("R2 store line6");
        snp(2'd1, mk(2, 6));         step("R3 earlier inv no viol");
        acc(1, mk(4, 3));            step("R2 store line3");
        snp(2'd1, mk(3, 1)); acc(0, mk(1, 7));
                                     step("R4 viol and R9 drop access");
        step("R4 pulse ends");
        acc(0, mk(6, 5));            step("R2 load line5");
        snp(2'd3, mk(6, 5));         step("R5 later snoop line5");
        acc(1, mk(6, 4));            step("R2 store line4");
        cmt = 1; acc(0, mk(1, 0));   step("R7 commit bulk inv");
        acc(1, mk(2, 3));            step("R2 store line3");
        acc(0, mk(2, 1));            step("R2 load line1");
        snp(2'd3, mk(2, 1));         step("R5 later snoop line1");
        sqh = 1;                     step("R8 squash keeps pinv");
        acc(1, mk(2, 3));            step("R2 store line3 again");
        sqh = 1; cmt = 1;            step("R9 squash over commit");
        snp(2'd1, mk(2, 1)); acc(0, mk(2, 1));
                                     step("R9 snoop then access");
        // Rank order at the extremes (R10)
        my_rank = 2'd0;
        acc(0, mk(9, 2));            step("R2 load line2");
        snp(2'd3, mk(9, 2));         step("R10 rank3 later than rank0");
        my_rank = 2'd3;
        snp(2'd2, mk(9, 2));         step("R10 rank2 earlier than rank3");

        // Constrained random mix
        for (int n = 0; n < 3000; n++) begin
            if (($urandom % 64) == 0) my_rank = 2'($urandom);
            acc_v  = (($urandom % 10) < 6);
            acc_st = 1'($urandom);
            acc_a  = mk($urandom % 2, $urandom % LINES);
            snp_v  = (($urandom % 2) == 0);
            snp_r  = 2'($urandom);
            snp_a  = mk($urandom % 2, $urandom % LINES);
            cmt    = (($urandom % 20) == 0);
            sqh    = (($urandom % 25) == 0);
            if (sqh)                              tg = "R8 random";
            else if (cmt)                         tg = "R7 random";
            else if (snp_v && snp_r < my_rank)    tg = "R4 R3 random";
            else if (snp_v && snp_r > my_rank)    tg = "R5 random";
            else if (snp_v)                       tg = "R6 random";
            else                                  tg = "R2 random";
            step(tg);
        end

        done = 1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end
endmodule